// File: doc/BRIEF.md
# Key-Protected System Control Register Bank

This block is a bank of 32-bit system control registers on a simple word-addressed bus. A single request strobe with a write-enable qualifies each access; writes land on the rising clock edge and read data is a combinational function of the address. The bank comes out of reset locked. While it is locked, ordinary registers ignore writes. Two dedicated key registers change the lock: one locks the bank and the other unlocks it, and each acts only when the low 16 bits of the written word match its magic key.

Each mapped offset has an access class: read-write, read-only or write-only. An access the class does not permit is flagged on a one-cycle error pulse. A write of that kind is discarded, while a read still returns the stored word. Offsets outside the map read as zero and are also flagged. A write to the reset-control register with bit 0 set, once it is accepted, produces a one-cycle soft-reset request. The 4-bit boot mode is taken from a strap input while reset is active and is read-only afterwards.

Register map (byte offsets, DATA_W = 32): 0x000 control (RW, bit 0 only), 0x004 lock key (WO), 0x008 unlock key (WO), 0x00C lock status (RO, bit 0), 0x010 PLL status (RO, reads 0x3F), 0x014 UART clock control (RW), 0x018 reset control (RW), 0x01C boot mode (RO, bits [3:0]), 0x020 ID code (RO, parameter), 0x024 calibration start (WO), 0x028 refresh start (WO), 0x02C DDR status (RO, reads 0), 0x040 + 4*i PLL control i (RW, i < N_PLL). Address bits [1:0] are ignored.

Top module: `sysctl_bank`

## Requirements
- R1: After reset, lock status (0x00C) reads 1, every PLL control register reads 0x0001A008, UART clock control (0x014) reads 0x00003F03, and boot mode (0x01C) reads the strap value held during reset; later changes of the strap do not alter it.
- R2: A write to 0x004 whose bits [15:0] equal 0x767B sets the lock status from the next cycle on; any other value leaves it unchanged.
- R3: A write to 0x008 whose bits [15:0] equal 0xDF0D clears the lock status from the next cycle on; any other value leaves it unchanged.
- R4: While the lock status is 1, writes to read-write and write-only registers leave them unchanged and raise no error; the key registers 0x004 and 0x008 stay writable.
- R5: Offsets 0x004, 0x008, 0x024 and 0x028 are write-only: a read returns the stored word (0 for the two key registers) and raises err_o.
- R6: Offsets 0x00C, 0x010, 0x01C, 0x020 and 0x02C are read-only: a write is discarded and raises err_o.
- R7: The control register at 0x000 stores only bit 0 of a write; bits [31:1] read as 0.
- R8: An accepted write to 0x018 with bit 0 set drives soft_rst_o high for exactly the next cycle; a write with bit 0 clear or a write while locked gives no pulse.
- R9: Unmapped offsets read as 0 and raise err_o, and writes to them change nothing.
- R10: err_o is high in the cycle after each rejected access and low after every permitted access and every idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| boot_strap_i | input | BOOT_W | Boot-mode strap, captured during reset |
| req_i | input | 1 | Access request strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address, word select in [ADDR_W-1:2] |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i, combinational |
| err_o | output | 1 | One-cycle pulse for a rejected access |
| soft_rst_o | output | 1 | One-cycle soft-reset request |

## Verification
The lock state and the commit of an ordinary write depend on each other at a cycle boundary. A key write changes the lock only for the access after it, and a soft-reset pulse from one access is still on the output while the next access may already be the relock key. The bench provokes this with back-to-back accesses: a reset-control write, then the lock key, then another reset-control write, then a key write followed directly by a register write. A per-cycle reference model judges the result by comparing err_o and soft_rst_o on every clock, and the read-back values after each burst.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  typedef enum logic [1:0] {ACC_NONE, ACC_RW, ACC_RO, ACC_WO} acc_e;

  localparam logic [15:0] LOCK_KEY   = 16'h767B;
  localparam logic [15:0] UNLOCK_KEY = 16'hDF0D;

  // word indices
  localparam int W_CTL    = 0;
  localparam int W_LOCK   = 1;
  localparam int W_UNLOCK = 2;
  localparam int W_LSTA   = 3;
  localparam int W_PSTA   = 4;
  localparam int W_UART   = 5;
  localparam int W_RST    = 6;
  localparam int W_BOOT   = 7;
  localparam int W_ID     = 8;
  localparam int W_CAL    = 9;
  localparam int W_REF    = 10;
  localparam int W_DSTA   = 11;
  localparam int W_PLL0   = 16;

  localparam logic [31:0] PLL_RST_VAL  = 32'h0001_A008;
  localparam logic [31:0] UART_RST_VAL = 32'h0000_3F03;
  localparam logic [31:0] PLL_STA_VAL  = 32'h0000_003F;
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int IDX_W     = 10,
  parameter int N_PLL     = 3,
  parameter int PLL_SEL_W = 2
) (
  input  logic [IDX_W-1:0]     idx_i,
  output acc_e                 acc_o,
  output logic                 pll_hit_o,
  output logic [PLL_SEL_W-1:0] pll_sel_o
);
  localparam logic [IDX_W-1:0] PLL_LO = IDX_W'(W_PLL0);
  localparam logic [IDX_W-1:0] PLL_HI = IDX_W'(W_PLL0 + N_PLL);

  logic [IDX_W-1:0] pll_off;
  assign pll_off   = idx_i - PLL_LO;
  assign pll_hit_o = (idx_i >= PLL_LO) && (idx_i < PLL_HI);
  assign pll_sel_o = pll_off[PLL_SEL_W-1:0];

  always_comb begin
    acc_o = ACC_NONE;
    unique case (idx_i)
      IDX_W'(W_CTL), IDX_W'(W_UART), IDX_W'(W_RST):             acc_o = ACC_RW;
      IDX_W'(W_LOCK), IDX_W'(W_UNLOCK), IDX_W'(W_CAL),
      IDX_W'(W_REF):                                            acc_o = ACC_WO;
      IDX_W'(W_LSTA), IDX_W'(W_PSTA), IDX_W'(W_BOOT),
      IDX_W'(W_ID), IDX_W'(W_DSTA):                             acc_o = ACC_RO;
      default: if (pll_hit_o) acc_o = ACC_RW;
    endcase
  end
endmodule

// File: rtl/sysctl_lock.sv
module sysctl_lock #(
  parameter int KEY_W = 16,
  parameter logic [KEY_W-1:0] LOCK_KEY   = '1,
  parameter logic [KEY_W-1:0] UNLOCK_KEY = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lock_wr_i,
  input  logic             unlock_wr_i,
  input  logic [KEY_W-1:0] key_i,
  output logic             locked_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_o <= 1'b1;
    end else if (lock_wr_i && key_i == LOCK_KEY) begin
      locked_o <= 1'b1;
    end else if (unlock_wr_i && key_i == UNLOCK_KEY) begin
      locked_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter int IDX_W     = 10,
  parameter int DATA_W    = 32,
  parameter int BOOT_W    = 4,
  parameter int N_PLL     = 3,
  parameter int PLL_SEL_W = 2,
  parameter logic [DATA_W-1:0] ID_VALUE = '0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [BOOT_W-1:0]    boot_strap_i,
  input  logic                 wr_en_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic                 pll_hit_i,
  input  logic [PLL_SEL_W-1:0] pll_sel_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic                 locked_i,
  output logic [DATA_W-1:0]    rdata_o
);
  logic                           ctl_q;
  logic [DATA_W-1:0]              uart_q, rst_q, cal_q, ref_q;
  logic [BOOT_W-1:0]              boot_q;
  logic [N_PLL-1:0][DATA_W-1:0]   pll_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= 1'b0;
      uart_q <= DATA_W'(UART_RST_VAL);
      rst_q  <= '0;
      cal_q  <= '0;
      ref_q  <= '0;
      boot_q <= boot_strap_i;  // strap sampled while reset is held
    end else if (wr_en_i) begin
      case (idx_i)
        IDX_W'(W_CTL):  ctl_q  <= wdata_i[0];
        IDX_W'(W_UART): uart_q <= wdata_i;
        IDX_W'(W_RST):  rst_q  <= wdata_i;
        IDX_W'(W_CAL):  cal_q  <= wdata_i;
        IDX_W'(W_REF):  ref_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < N_PLL; g++) begin : g_pll
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pll_q[g] <= DATA_W'(PLL_RST_VAL);
      end else if (wr_en_i && pll_hit_i && pll_sel_i == PLL_SEL_W'(g)) begin
        pll_q[g] <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (idx_i)
      IDX_W'(W_CTL):  rdata_o = DATA_W'(ctl_q);
      IDX_W'(W_LSTA): rdata_o = DATA_W'(locked_i);
      IDX_W'(W_PSTA): rdata_o = DATA_W'(PLL_STA_VAL);
      IDX_W'(W_UART): rdata_o = uart_q;
      IDX_W'(W_RST):  rdata_o = rst_q;
      IDX_W'(W_BOOT): rdata_o = DATA_W'(boot_q);
      IDX_W'(W_ID):   rdata_o = ID_VALUE;
      IDX_W'(W_CAL):  rdata_o = cal_q;
      IDX_W'(W_REF):  rdata_o = ref_q;
      default: if (pll_hit_i) rdata_o = pll_q[pll_sel_i];
    endcase
  end
endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int KEY_W  = 16,
  parameter int BOOT_W = 4,
  parameter int N_PLL  = 3,
  parameter logic [DATA_W-1:0] ID_VALUE = DATA_W'(32'h0A5C_1001)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BOOT_W-1:0] boot_strap_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic              soft_rst_o
);
  localparam int IDX_W     = ADDR_W - 2;
  localparam int PLL_SEL_W = (N_PLL > 1) ? $clog2(N_PLL) : 1;

  logic [IDX_W-1:0]     idx;
  acc_e                 acc;
  logic                 pll_hit;
  logic [PLL_SEL_W-1:0] pll_sel;
  logic                 locked;
  logic                 wr, rd, wr_ok, rd_ok, lock_wr, unlock_wr, commit;

  assign idx = addr_i[ADDR_W-1:2];

  sysctl_decode #(.IDX_W(IDX_W), .N_PLL(N_PLL), .PLL_SEL_W(PLL_SEL_W)) u_decode (
    .idx_i(idx), .acc_o(acc), .pll_hit_o(pll_hit), .pll_sel_o(pll_sel)
  );

  assign wr        = req_i & we_i;
  assign rd        = req_i & ~we_i;
  assign wr_ok     = wr & (acc == ACC_RW || acc == ACC_WO);
  assign rd_ok     = rd & (acc == ACC_RW || acc == ACC_RO);
  assign lock_wr   = wr & (idx == IDX_W'(W_LOCK));
  assign unlock_wr = wr & (idx == IDX_W'(W_UNLOCK));
  assign commit    = wr_ok & ~locked & ~lock_wr & ~unlock_wr;

  sysctl_lock #(.KEY_W(KEY_W), .LOCK_KEY(KEY_W'(LOCK_KEY)), .UNLOCK_KEY(KEY_W'(UNLOCK_KEY))) u_lock (
    .clk_i, .rst_ni, .lock_wr_i(lock_wr), .unlock_wr_i(unlock_wr),
    .key_i(wdata_i[KEY_W-1:0]), .locked_o(locked)
  );

  sysctl_regfile #(
    .IDX_W(IDX_W), .DATA_W(DATA_W), .BOOT_W(BOOT_W), .N_PLL(N_PLL),
    .PLL_SEL_W(PLL_SEL_W), .ID_VALUE(ID_VALUE)
  ) u_regs (
    .clk_i, .rst_ni, .boot_strap_i, .wr_en_i(commit), .idx_i(idx),
    .pll_hit_i(pll_hit), .pll_sel_i(pll_sel), .wdata_i, .locked_i(locked),
    .rdata_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o      <= 1'b0;
      soft_rst_o <= 1'b0;
    end else begin
      err_o      <= req_i & ~(wr_ok | rd_ok);
      soft_rst_o <= commit & (idx == IDX_W'(W_RST)) & wdata_i[0];
    end
  end
endmodule

// File: rtl/sysctl_bank_chk.sv
module sysctl_bank_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int N_PLL  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              err_o,
  input logic              soft_rst_o,
  input logic              locked
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] I_LOCK   = IDX_W'(1);
  localparam logic [IDX_W-1:0] I_UNLOCK = IDX_W'(2);
  localparam logic [IDX_W-1:0] I_RST    = IDX_W'(6);
  localparam logic [IDX_W-1:0] I_GAP    = IDX_W'(12);
  localparam logic [IDX_W-1:0] I_PLL0   = IDX_W'(16);
  localparam logic [IDX_W-1:0] I_PLLE   = IDX_W'(16 + N_PLL);

  logic [IDX_W-1:0] idx;
  assign idx = addr_i[ADDR_W-1:2];

  assert_lock_key_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && idx == I_LOCK && wdata_i[15:0] == 16'h767B) |=> locked);

  assert_unlock_key_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && idx == I_UNLOCK && wdata_i[15:0] == 16'hDF0D) |=> !locked);

  assert_lock_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i && (idx == I_LOCK || idx == I_UNLOCK)) |=> $stable(locked));

  assert_soft_source_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |-> $past(req_i && we_i && idx == I_RST && wdata_i[0] && !locked));

  assert_err_source_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(req_i));

  assert_unmapped_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx >= I_GAP && (idx < I_PLL0 || idx >= I_PLLE)) |-> rdata_o == '0);
endmodule

bind sysctl_bank sysctl_bank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_PLL(N_PLL)) chk_i (.*);

// File: tb/sysctl_bank_tb.sv
module sysctl_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ID_EXP = 32'h0A5C_1001;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  boot_strap_i = 4'hA;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        err_o, soft_rst_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sysctl_bank dut_i (.*);

  // reference model
  bit          m_lock, m_err, m_soft;
  logic [3:0]  m_boot;
  logic [31:0] m_mem [int];

  function automatic bit can_wr(int i);
    return i inside {0, 1, 2, 5, 6, 9, 10, 16, 17, 18};
  endfunction
  function automatic bit can_rd(int i);
    return i inside {0, 3, 4, 5, 6, 7, 8, 11, 16, 17, 18};
  endfunction
  function automatic logic [31:0] exp_rd(int i);
    case (i)
      1, 2:   return 32'h0;
      3:      return {31'h0, m_lock};
      4:      return 32'h3F;
      7:      return {28'h0, m_boot};
      8:      return ID_EXP;
      11:     return 32'h0;
      default: return m_mem.exists(i) ? m_mem[i] : 32'h0;
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_lock = 1; m_err = 0; m_soft = 0; m_boot = boot_strap_i;
      m_mem.delete();
      m_mem[0] = 0; m_mem[5] = 32'h0000_3F03; m_mem[6] = 0; m_mem[9] = 0; m_mem[10] = 0;
      for (int k = 16; k < 19; k++) m_mem[k] = 32'h0001_A008;
    end else begin
      int i;
      i = int'(addr_i[11:2]);
      m_err = 0; m_soft = 0;
      if (req_i && we_i) begin
        if (!can_wr(i)) m_err = 1;
        else if (i == 1) begin if (wdata_i[15:0] == 16'h767B) m_lock = 1; end
        else if (i == 2) begin if (wdata_i[15:0] == 16'hDF0D) m_lock = 0; end
        else if (!m_lock) begin
          m_mem[i] = (i == 0) ? (wdata_i & 32'h1) : wdata_i;
          if (i == 6 && wdata_i[0]) m_soft = 1;
        end
      end else if (req_i) begin
        if (!can_rd(i)) m_err = 1;
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison of registered outputs
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk({31'h0, err_o}, {31'h0, m_err}, "R10 err_o");
      chk({31'h0, soft_rst_o}, {31'h0, m_soft}, "R8 soft_rst_o");
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 1; addr_i = 12'(a); wdata_i = d;
  endtask

  task automatic rd(input int a, input string tag);
    @(negedge clk_i);
    req_i = 1; we_i = 0; addr_i = 12'(a); wdata_i = 32'hDEAD_BEEF;
    #1 chk(rdata_o, exp_rd(a >> 2), tag);
  endtask

  task automatic idle();
    @(negedge clk_i);
    req_i = 0; we_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1 reset state
    rd('h00C, "R1 lock status after reset"); chk(rdata_o, 32'h1, "R1 lock status literal");
    rd('h040, "R1 pll0 reset"); chk(rdata_o, 32'h0001_A008, "R1 pll0 literal");
    rd('h044, "R1 pll1 reset");
    rd('h048, "R1 pll2 reset");
    rd('h014, "R1 uart reset"); chk(rdata_o, 32'h0000_3F03, "R1 uart literal");
    boot_strap_i = 4'h5;
    rd('h01C, "R1 boot mode keeps strap"); chk(rdata_o, 32'hA, "R1 boot literal");
    // R4 locked writes ignored
    wr('h040, 32'h1234_5678); wr('h018, 32'h1); wr('h024, 32'h77);
    rd('h040, "R4 pll0 locked write ignored");
    rd('h018, "R4 reset ctrl locked write ignored");
    rd('h024, "R5 cal start locked write ignored");
    // R3 unlock
    wr('h008, 32'h0000_DF0E); rd('h00C, "R3 wrong unlock key"); chk(rdata_o, 32'h1, "R3 still locked");
    wr('h008, 32'hABCD_DF0D); rd('h00C, "R3 unlock key"); chk(rdata_o, 32'h0, "R3 unlocked");
    // R7 control bit 0
    wr('h000, 32'hFFFF_FFFE); rd('h000, "R7 bit0 only, zero");
    wr('h003, 32'h0000_0003); rd('h000, "R7 bit0 only, one"); chk(rdata_o, 32'h1, "R7 literal");
    // R4 unlocked writes land
    wr('h044, 32'hCAFE_0001); wr('h014, 32'h0000_0A01); idle();
    rd('h044, "R4 pll1 written"); rd('h014, "R4 uart written");
    // R6 read-only writes discarded
    wr('h00C, 32'h0); wr('h01C, 32'hF); wr('h020, 32'h0); wr('h010, 32'h0); wr('h02C, 32'h1);
    rd('h00C, "R6 lock status unchanged"); rd('h01C, "R6 boot unchanged");
    rd('h020, "R6 id unchanged"); rd('h010, "R6 pll status unchanged"); rd('h02C, "R6 ddr status");
    // R5 write-only reads flagged, stored word returned
    wr('h024, 32'h55); wr('h028, 32'hAA);
    rd('h024, "R5 cal read back"); rd('h028, "R5 refresh read back");
    rd('h004, "R5 lock key reads zero"); rd('h008, "R5 unlock key reads zero");
    // R9 unmapped
    rd('h030, "R9 gap offset"); rd('h04C, "R9 past last pll"); rd('hFFC, "R9 top offset");
    wr('h03C, 32'h1111_1111); rd('h03C, "R9 unmapped write dropped");
    // R8 soft reset, back to back with relock
    wr('h018, 32'h1); wr('h018, 32'h0); wr('h018, 32'h3); wr('h004, 32'h0000_767B);
    wr('h018, 32'h1); idle(); idle();
    rd('h018, "R8 reset ctrl after relock"); chk(rdata_o, 32'h3, "R8 last accepted value");
    // R2 lock keys
    wr('h008, 32'hDF0D); wr('h004, 32'h0000_767C); rd('h00C, "R2 wrong lock key");
    wr('h004, 32'hFFFF_767B); wr('h040, 32'h0BAD_0BAD); rd('h00C, "R2 lock key");
    rd('h040, "R2 write right after relock ignored");
    wr('h008, 32'hDF0D); wr('h018, 32'h2); idle(); idle();
    rd('h018, "R8 bit0 clear, no pulse");
    idle(); idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule